// File: doc/BRIEF.md
# Low-Power Mode Controller with Retention

This block sequences a radio subsystem between four operating modes: active, doze, deep sleep and power-down. Firmware asks for doze or deep sleep through request inputs. Three wake sources bring the subsystem back: an external interrupt, a host bus resume and a sequencer timer expiry. The controller drives the main-clock enable, the analog power enable and the digital core power enable. It also runs a two-step handshake with the retention storage. On the way into deep sleep, the core state is saved before core power is removed. On the way out, the core is powered first and its state is restored afterwards.

Two host enable pins control the supply side. One pin belongs to the radio section and one to a companion section. The shared regulators run while either pin is high. Each section's reset follows only its own pin. A low radio pin forces power-down: the sequencer drops to its off state and forgets any earlier mode. When the pin returns high, the block starts cold, with no restore.

Top module: `lpm_ctrl`

## Requirements
- R1: `reg_en_o` is high in the same cycle whenever any bit of `host_en_i` is high, and low only when all bits are low.
- R2: `sect_rst_o[i]` is the inverse of `host_en_i[i]` in the same cycle, and no other pin affects it (bit 0 is the radio section).
- R3: While the radio pin `host_en_i[0]` is low, `main_clk_en_o`, `ana_pwr_en_o`, `core_pwr_en_o`, `save_o` and `restore_o` are low in that same cycle. At the next edge `mode_o` becomes 0 (power-down).
- R4: `mode_o` encodes the state as follows: 0 power-down, 1 active, 2 doze, 3 saving, 4 deep sleep, 5 core power-up, 6 restoring. From power-down, a high radio pin moves to active at the next edge with no restore pulse. In active, clock, analog and core enables are all high.
- R5: In active, `doze_req_i` moves to doze at the next edge. In doze, the clock and analog enables are low and the core enable stays high.
- R6: In doze, any bit of `wake_i` returns the controller to active at the next edge. `wake_i` bits are: 0 external interrupt, 1 host bus resume, 2 sequencer timer.
- R7: In active, `sleep_req_i` wins over `doze_req_i` and enters saving. In saving, `save_o`, the core enable and the clock enable are high until `save_done_i`. The edge after `save_done_i` enters deep sleep, with the core enable and all other enables low.
- R8: In deep sleep, a wake moves to core power-up. There the core enable is high and `restore_o` is low until `pwr_good_i`. Then `restore_o` is high for exactly one cycle (restoring), and the controller returns to active.
- R9: A wake that arrives during saving is held. Deep sleep then lasts exactly one cycle before core power-up, with no further wake input needed.
- R10: Wake inputs in active, and sleep or doze requests outside active, leave `mode_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_en_i | input | NUM_SECT | Host enable pins, bit 0 is the radio section |
| doze_req_i | input | 1 | Firmware request for doze |
| sleep_req_i | input | 1 | Firmware request for deep sleep |
| wake_i | input | NUM_WAKE | Wake sources: interrupt, bus resume, timer |
| save_done_i | input | 1 | Retention save acknowledge |
| pwr_good_i | input | 1 | Core power-good acknowledge |
| reg_en_o | output | 1 | Shared regulator enable |
| sect_rst_o | output | NUM_SECT | Per-section reset, active high |
| main_clk_en_o | output | 1 | Main clock enable |
| ana_pwr_en_o | output | 1 | Radio/analog power enable |
| core_pwr_en_o | output | 1 | Digital core power enable |
| save_o | output | 1 | Retention save request |
| restore_o | output | 1 | Retention restore strobe |
| mode_o | output | 3 | Current mode code |

## Verification
The regulator enable, the section resets and the forced-off gating on a low radio pin are combinational. The bench checks them one time step after it drives the pins, before any clock edge. Every mode change and every enable that follows from the mode is due one clock edge after the request, wake or acknowledge. The bench changes inputs just after a rising edge and samples just after the next one. Where a response must not come yet, the bench leaves cycles idle and samples in each of them. This covers saving without an acknowledge, power-up without power-good, and deep sleep without a wake. The bench also shows that a latched wake ends deep sleep after exactly one cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_ACT     = 3'd1,
    ST_DOZE    = 3'd2,
    ST_SAVE    = 3'd3,
    ST_SLEEP   = 3'd4,
    ST_WAKE    = 3'd5,
    ST_RESTORE = 3'd6
  } lpm_state_e;

  localparam int unsigned STATE_W = 3;
endpackage

// File: rtl/lpm_supply.sv
module lpm_supply #(
  parameter int unsigned NUM_SECT = 2
) (
  input  logic [NUM_SECT-1:0] host_en_i,
  output logic                reg_en_o,
  output logic [NUM_SECT-1:0] sect_rst_o
);
  assign reg_en_o = |host_en_i;

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_rst
    assign sect_rst_o[g] = ~host_en_i[g];
  end
endmodule

// File: rtl/lpm_wake.sv
module lpm_wake #(
  parameter int unsigned NUM_WAKE = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_WAKE-1:0] wake_i,
  input  logic                arm_i,
  input  logic                hold_i,
  output logic                wake_any_o,
  output logic                pend_o
);
  logic pend_q, pend_d;

  assign wake_any_o = |wake_i;

  always_comb begin
    if (arm_i)       pend_d = pend_q | wake_any_o;
    else if (hold_i) pend_d = pend_q;
    else             pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // a wake seen while saving must stay held until it is used
  AST_PEND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && wake_any_o) |=> pend_o); // R9
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               radio_on_i,
  input  logic               doze_req_i,
  input  logic               sleep_req_i,
  input  logic               wake_any_i,
  input  logic               wake_pend_i,
  input  logic               save_done_i,
  input  logic               pwr_good_i,
  output logic [STATE_W-1:0] state_o,
  output logic               clk_en_o,
  output logic               ana_en_o,
  output logic               core_en_o,
  output logic               save_o,
  output logic               restore_o
);
  lpm_state_e state_q, state_d;
  logic clk_dec, ana_dec, core_dec, save_dec, rest_dec;

  always_comb begin
    state_d = state_q;
    if (!radio_on_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:     state_d = ST_ACT;
        ST_ACT:     if (sleep_req_i)     state_d = ST_SAVE;
                    else if (doze_req_i) state_d = ST_DOZE;
        ST_DOZE:    if (wake_any_i)      state_d = ST_ACT;
        ST_SAVE:    if (save_done_i)     state_d = ST_SLEEP;
        ST_SLEEP:   if (wake_any_i || wake_pend_i) state_d = ST_WAKE;
        ST_WAKE:    if (pwr_good_i)      state_d = ST_RESTORE;
        ST_RESTORE: state_d = ST_ACT;
        default:    state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  always_comb begin
    clk_dec  = 1'b0;
    ana_dec  = 1'b0;
    core_dec = 1'b0;
    save_dec = 1'b0;
    rest_dec = 1'b0;
    unique case (state_q)
      ST_ACT:     begin clk_dec = 1'b1; ana_dec = 1'b1; core_dec = 1'b1; end
      ST_DOZE:    core_dec = 1'b1;
      ST_SAVE:    begin clk_dec = 1'b1; core_dec = 1'b1; save_dec = 1'b1; end
      ST_WAKE:    core_dec = 1'b1;
      ST_RESTORE: begin clk_dec = 1'b1; core_dec = 1'b1; rest_dec = 1'b1; end
      default:    ;
    endcase
  end

  // a low radio pin forces every enable off at once
  assign clk_en_o  = clk_dec  & radio_on_i;
  assign ana_en_o  = ana_dec  & radio_on_i;
  assign core_en_o = core_dec & radio_on_i;
  assign save_o    = save_dec & radio_on_i;
  assign restore_o = rest_dec & radio_on_i;
  assign state_o   = state_q;

  AST_SAVE_BEFORE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_SLEEP) |-> ($past(state_q) == ST_SAVE && $past(save_done_i))); // R7
  AST_RESTORE_AFTER_PG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESTORE) |-> ($past(state_q) == ST_WAKE && $past(pwr_good_i))); // R8
  AST_RESTORE_ONE_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |=> !restore_o); // R8
  AST_PEND_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && wake_pend_i) |=> (state_q == ST_WAKE || state_q == ST_OFF)); // R9
  AST_COLD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACT) |-> ($past(state_q) != ST_OFF || !$past(restore_o))); // R4
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned NUM_SECT   = 2,
  parameter int unsigned NUM_WAKE   = 3,
  parameter int unsigned RADIO_SECT = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SECT-1:0] host_en_i,
  input  logic                doze_req_i,
  input  logic                sleep_req_i,
  input  logic [NUM_WAKE-1:0] wake_i,
  input  logic                save_done_i,
  input  logic                pwr_good_i,
  output logic                reg_en_o,
  output logic [NUM_SECT-1:0] sect_rst_o,
  output logic                main_clk_en_o,
  output logic                ana_pwr_en_o,
  output logic                core_pwr_en_o,
  output logic                save_o,
  output logic                restore_o,
  output logic [STATE_W-1:0]  mode_o
);
  logic wake_any, wake_pend, in_save, in_sleep;

  lpm_supply #(.NUM_SECT(NUM_SECT)) u_supply (
    .host_en_i  (host_en_i),
    .reg_en_o   (reg_en_o),
    .sect_rst_o (sect_rst_o)
  );

  assign in_save  = (mode_o == STATE_W'(ST_SAVE));
  assign in_sleep = (mode_o == STATE_W'(ST_SLEEP));

  lpm_wake #(.NUM_WAKE(NUM_WAKE)) u_wake (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wake_i     (wake_i),
    .arm_i      (in_save),
    .hold_i     (in_sleep),
    .wake_any_o (wake_any),
    .pend_o     (wake_pend)
  );

  lpm_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .radio_on_i  (host_en_i[RADIO_SECT]),
    .doze_req_i  (doze_req_i),
    .sleep_req_i (sleep_req_i),
    .wake_any_i  (wake_any),
    .wake_pend_i (wake_pend),
    .save_done_i (save_done_i),
    .pwr_good_i  (pwr_good_i),
    .state_o     (mode_o),
    .clk_en_o    (main_clk_en_o),
    .ana_en_o    (ana_pwr_en_o),
    .core_en_o   (core_pwr_en_o),
    .save_o      (save_o),
    .restore_o   (restore_o)
  );

  AST_SAFE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_en_i == '0) |-> (!reg_en_o && !main_clk_en_o && !ana_pwr_en_o
                           && !core_pwr_en_o && !save_o && !restore_o)); // R3
  AST_PWRDN_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_en_i[RADIO_SECT] |=> (mode_o == STATE_W'(ST_OFF) || host_en_i[RADIO_SECT])); // R3
endmodule

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_en = 2'b00;
  logic       doze_req = 1'b0, sleep_req = 1'b0;
  logic [2:0] wake = 3'b000;
  logic       save_done = 1'b0, pwr_good = 1'b0;
  logic       reg_en, clk_en, ana_en, core_en, save, restore;
  logic [1:0] sect_rst;
  logic [2:0] mode;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_ctrl u_lpm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .host_en_i(host_en),
    .doze_req_i(doze_req), .sleep_req_i(sleep_req), .wake_i(wake),
    .save_done_i(save_done), .pwr_good_i(pwr_good),
    .reg_en_o(reg_en), .sect_rst_o(sect_rst), .main_clk_en_o(clk_en),
    .ana_pwr_en_o(ana_en), .core_pwr_en_o(core_en), .save_o(save),
    .restore_o(restore), .mode_o(mode)
  );

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // {clk, ana, core, save, restore}
  function automatic int outs();
    return {27'd0, clk_en, ana_en, core_en, save, restore};
  endfunction

  task automatic t_reset();
    check("R4 reset mode", mode, 0);
    check("R3 reset outputs off", outs(), 0);
    check("R1 reset reg_en", reg_en, 0);
    check("R2 reset resets", sect_rst, 3);
  endtask

  task automatic t_supply();
    host_en = 2'b10; #1;
    check("R1 reg_en on companion pin", reg_en, 1);
    check("R2 radio reset ignores companion", sect_rst, 2'b01);
    check("R3 radio off outputs", outs(), 0);
    tick();
    check("R3 companion alone keeps power-down", mode, 0);
    host_en = 2'b01; #1;
    check("R1 reg_en on radio pin", reg_en, 1);
    check("R2 resets follow own pin", sect_rst, 2'b10);
    tick();
    check("R4 cold start active", mode, 1);
    check("R4 active outputs no restore", outs(), 5'b11100);
  endtask

  task automatic t_doze();
    doze_req = 1'b1;
    tick();
    doze_req = 1'b0;
    check("R5 doze mode", mode, 2);
    check("R5 doze outputs", outs(), 5'b00100);
    tick();
    check("R6 doze holds without wake", mode, 2);
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    check("R10 sleep req ignored in doze", mode, 2);
    wake = 3'b010;
    tick();
    wake = 3'b000;
    check("R6 bus resume wakes doze", mode, 1);
    doze_req = 1'b1;
    tick();
    doze_req = 1'b0;
    wake = 3'b001;
    tick();
    wake = 3'b000;
    check("R6 interrupt wakes doze", mode, 1);
  endtask

  task automatic t_ignore();
    wake = 3'b111;
    tick();
    wake = 3'b000;
    check("R10 wake ignored in active", mode, 1);
    check("R10 active outputs kept", outs(), 5'b11100);
  endtask

  task automatic t_sleep();
    sleep_req = 1'b1; doze_req = 1'b1;
    tick();
    sleep_req = 1'b0; doze_req = 1'b0;
    check("R7 sleep priority over doze", mode, 3);
    check("R7 saving outputs", outs(), 5'b10110);
    tick();
    check("R7 save holds without ack", mode, 3);
    save_done = 1'b1;
    tick();
    save_done = 1'b0;
    check("R7 deep sleep", mode, 4);
    check("R7 deep sleep outputs off", outs(), 0);
    tick(); tick();
    check("R8 sleep holds without wake", mode, 4);
    wake = 3'b100;
    tick();
    wake = 3'b000;
    check("R8 timer wake powers core", mode, 5);
    check("R8 power-up outputs", outs(), 5'b00100);
    tick();
    check("R8 waits for power-good", mode, 5);
    pwr_good = 1'b1;
    tick();
    check("R8 restoring", mode, 6);
    check("R8 restore strobe", outs(), 5'b10101);
    tick();
    pwr_good = 1'b0;
    check("R8 back to active", mode, 1);
    check("R8 restore single cycle", restore, 0);
  endtask

  task automatic t_latched();
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    wake = 3'b001;
    tick();
    wake = 3'b000;
    check("R9 still saving", mode, 3);
    save_done = 1'b1;
    tick();
    save_done = 1'b0;
    check("R9 enters deep sleep", mode, 4);
    check("R9 core off in sleep", core_en, 0);
    tick();
    check("R9 latched wake exits", mode, 5);
    pwr_good = 1'b1;
    tick(); tick();
    pwr_good = 1'b0;
    check("R9 returns active", mode, 1);
  endtask

  task automatic t_powerdown();
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    host_en = 2'b00; #1;
    check("R1 reg_en off both low", reg_en, 0);
    check("R3 immediate safe outputs", outs(), 0);
    tick();
    check("R3 power-down mode", mode, 0);
    host_en = 2'b11;
    tick();
    check("R4 restart active without restore", mode, 1);
    check("R4 restart outputs", outs(), 5'b11100);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    #1;
    t_reset();
    tick();
    t_supply();
    t_doze();
    t_ignore();
    t_sleep();
    t_latched();
    t_powerdown();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule